// File: doc/BRIEF.md
# Pipeline Control-Hazard and Interlock Unit

This block is the purely combinational steering logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the instruction class in decode and in execute, at the decode-stage source register numbers and their read-enables, at the destination numbers and write-enables of the three older stages, and at the zero flag computed in execute. From these it chooses where the next fetch address comes from, whether the decode and execute instruction registers are loaded with a bubble, and whether the front of the pipe must wait for a register value.

Control transfers cancel work rather than wait. A branch resolved in execute discards both younger instructions and costs two bubbles. An unconditional jump recognised in decode discards the single instruction behind it and costs one bubble. The older instruction always wins: a taken branch in execute overrides both a jump and an interlock in decode, because the decode-stage instruction is then on the wrong path. While an interlock is active the surrounding pipeline holds the PC and the decode register, and the unit puts a bubble into execute.

Top module: `ctrl_hazard_unit`

## Requirements
- R1: `stall` is 1 when the first source is read (`src1_rd_d`=1), is not register 0, and equals the destination of any of the execute, memory or writeback stages whose write-enable is 1, unless R4 applies.
- R2: The same interlock as R1 holds for the second source, gated by `src2_rd_d`; with both read-enables 0, no match raises `stall`.
- R3: A source equal to register 0 never raises `stall`, even when it equals a write-enabled destination.
- R4: The execute stage holds a taken branch when its class is BEQZ (3) with `zero_e`=1 or BNEZ (4) with `zero_e`=0; a taken branch forces `stall` to 0.
- R5: Class codes: ALU 0, LOAD 1, STORE 2, BEQZ 3, BNEZ 4, J 5, JAL 6, JR 7, JALR 8, NOP 9; codes 10 to 15 act as plain non-control classes.
- R6: `next_pc_sel` encodes 0 = PC+4, 1 = absolute jump target, 2 = register-indirect target, 3 = branch target. A taken branch selects 3; otherwise, if `stall` is 0, J or JAL in decode selects 1 and JR or JALR selects 2; otherwise 0.
- R7: `dec_ir_nop` is 1 when a taken branch is in execute, or when decode holds J, JAL, JR or JALR and `stall` is 0.
- R8: `exe_ir_nop` is 1 when a taken branch is in execute or `stall` is 1, so a taken branch bubbles both younger instructions.
- R9: While `stall` is 1, `next_pc_sel` is 0 and `dec_ir_nop` is 0, so a jump waiting on an interlock is not redirected until its operands are ready.
- R10: A branch that is not taken (BEQZ with `zero_e`=0, BNEZ with `zero_e`=1) kills nothing and leaves `stall` to R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_d | input | 4 | Instruction class in decode |
| src1_d | input | 5 | First source register number in decode |
| src1_rd_d | input | 1 | First source is actually read |
| src2_d | input | 5 | Second source register number in decode |
| src2_rd_d | input | 1 | Second source is actually read |
| cls_e | input | 4 | Instruction class in execute |
| zero_e | input | 1 | Branch operand equals zero |
| dst_e | input | 5 | Destination register in execute |
| wen_e | input | 1 | Execute instruction writes a register |
| dst_m | input | 5 | Destination register in memory |
| wen_m | input | 1 | Memory instruction writes a register |
| dst_w | input | 5 | Destination register in writeback |
| wen_w | input | 1 | Writeback instruction writes a register |
| next_pc_sel | output | 2 | Fetch address source |
| dec_ir_nop | output | 1 | Load a bubble into the decode register |
| exe_ir_nop | output | 1 | Load a bubble into the execute register |
| stall | output | 1 | Hold PC and decode register |

## Verification
The two functions that collide in one cycle are the register interlock in decode and a branch resolving in execute, and likewise a jump in decode against either of them. The stimulus draws register numbers from a narrow range so source and destination matches are frequent, mixes all classes and zero-flag values, and adds directed cases where a taken branch, a jump and a live dependence all appear together. Each cycle the four outputs are compared with values computed by bench functions from the priority rules alone.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int CLS_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 4'd0,
    CLS_LOAD  = 4'd1,
    CLS_STORE = 4'd2,
    CLS_BEQZ  = 4'd3,
    CLS_BNEZ  = 4'd4,
    CLS_J     = 4'd5,
    CLS_JAL   = 4'd6,
    CLS_JR    = 4'd7,
    CLS_JALR  = 4'd8,
    CLS_NOP   = 4'd9
  } cls_e_t;

  typedef enum logic [SEL_W-1:0] {
    PCS_SEQ = 2'd0,
    PCS_ABS = 2'd1,
    PCS_IND = 2'd2,
    PCS_BR  = 2'd3
  } pc_sel_t;
endpackage

// File: rtl/hzd_dep_check.sv
module hzd_dep_check #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2,
  parameter int NSTG  = 3
) (
  input  logic [NSRC-1:0][REG_W-1:0] src,
  input  logic [NSRC-1:0]            src_rd,
  input  logic [NSTG-1:0][REG_W-1:0] dst,
  input  logic [NSTG-1:0]            wen,
  output logic                       dep_hit
);
  localparam int NPAIR = NSRC * NSTG;

  logic [NPAIR-1:0] pair_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic src_live;
    assign src_live = src_rd[k] && (src[k] != '0);
    for (genvar s = 0; s < NSTG; s++) begin : g_stg
      assign pair_hit[k*NSTG+s] = src_live && wen[s] && (src[k] == dst[s]);
    end
  end

  assign dep_hit = |pair_hit;

  always_comb begin
    if (!src_rd[0] && !src_rd[1]) begin
      p_no_read_no_dep_r2: assert (!dep_hit) else $error("dependence without a read source");
    end
    if (src[0] == '0 && src[1] == '0) begin
      p_zero_reg_r3: assert (!dep_hit) else $error("register zero produced a dependence");
    end
  end
endmodule

// File: rtl/hzd_branch_eval.sv
module hzd_branch_eval
  import hzd_pkg::*;
(
  input  logic [CLS_W-1:0] cls_e,
  input  logic             zero_e,
  output logic             taken
);
  logic is_beqz, is_bnez;

  assign is_beqz = (cls_e == CLS_BEQZ);
  assign is_bnez = (cls_e == CLS_BNEZ);
  assign taken   = (is_beqz && zero_e) || (is_bnez && !zero_e);

  always_comb begin
    if (!is_beqz && !is_bnez) begin
      p_non_branch_r10: assert (!taken) else $error("non-branch class resolved as taken");
    end
  end
endmodule

// File: rtl/hzd_select.sv
module hzd_select
  import hzd_pkg::*;
(
  input  logic [CLS_W-1:0] cls_d,
  input  logic             taken,
  input  logic             dep_hit,
  output logic [SEL_W-1:0] next_pc_sel,
  output logic             dec_ir_nop,
  output logic             exe_ir_nop,
  output logic             stall
);
  logic jmp_abs, jmp_ind, jmp_any, redirect_ok;
  pc_sel_t sel;

  assign jmp_abs     = (cls_d == CLS_J)  || (cls_d == CLS_JAL);
  assign jmp_ind     = (cls_d == CLS_JR) || (cls_d == CLS_JALR);
  assign jmp_any     = jmp_abs || jmp_ind;
  assign stall       = dep_hit && !taken;
  assign redirect_ok = !stall;

  always_comb begin
    if (taken)                    sel = PCS_BR;
    else if (redirect_ok && jmp_abs) sel = PCS_ABS;
    else if (redirect_ok && jmp_ind) sel = PCS_IND;
    else                          sel = PCS_SEQ;
  end

  assign next_pc_sel = sel;
  assign dec_ir_nop  = taken || (jmp_any && redirect_ok);
  assign exe_ir_nop  = taken || stall;

  always_comb begin
    if (jmp_abs && !taken && !stall) begin
      p_abs_jump_r6: assert (next_pc_sel == PCS_ABS) else $error("absolute jump not selected");
    end
    if (taken) begin
      p_branch_wins_r6: assert (next_pc_sel == PCS_BR) else $error("taken branch lost priority");
    end
  end
endmodule

// File: rtl/ctrl_hazard_unit.sv
module ctrl_hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [3:0]       cls_d,
  input  logic [REG_W-1:0] src1_d,
  input  logic             src1_rd_d,
  input  logic [REG_W-1:0] src2_d,
  input  logic             src2_rd_d,
  input  logic [3:0]       cls_e,
  input  logic             zero_e,
  input  logic [REG_W-1:0] dst_e,
  input  logic             wen_e,
  input  logic [REG_W-1:0] dst_m,
  input  logic             wen_m,
  input  logic [REG_W-1:0] dst_w,
  input  logic             wen_w,
  output logic [1:0]       next_pc_sel,
  output logic             dec_ir_nop,
  output logic             exe_ir_nop,
  output logic             stall
);
  localparam int NSRC = 2;
  localparam int NSTG = 3;

  logic [NSRC-1:0][REG_W-1:0] src_v;
  logic [NSRC-1:0]            src_rd_v;
  logic [NSTG-1:0][REG_W-1:0] dst_v;
  logic [NSTG-1:0]            wen_v;
  logic                       dep_hit;
  logic                       taken;

  assign src_v    = {src2_d, src1_d};
  assign src_rd_v = {src2_rd_d, src1_rd_d};
  assign dst_v    = {dst_w, dst_m, dst_e};
  assign wen_v    = {wen_w, wen_m, wen_e};

  hzd_dep_check #(.REG_W(REG_W), .NSRC(NSRC), .NSTG(NSTG)) u_dep (
    .src    (src_v),
    .src_rd (src_rd_v),
    .dst    (dst_v),
    .wen    (wen_v),
    .dep_hit(dep_hit)
  );

  hzd_branch_eval u_br (
    .cls_e (cls_e),
    .zero_e(zero_e),
    .taken (taken)
  );

  hzd_select u_sel (
    .cls_d      (cls_d),
    .taken      (taken),
    .dep_hit    (dep_hit),
    .next_pc_sel(next_pc_sel),
    .dec_ir_nop (dec_ir_nop),
    .exe_ir_nop (exe_ir_nop),
    .stall      (stall)
  );

  always_comb begin
    if (taken) begin
      p_taken_no_stall_r4: assert (!stall) else $error("stall while branch taken");
      p_kill_two_r8: assert (dec_ir_nop && exe_ir_nop) else $error("taken branch left a younger instruction");
    end
    if (stall) begin
      p_stall_holds_r9: assert (next_pc_sel == 2'd0 && !dec_ir_nop && exe_ir_nop)
        else $error("stall did not hold the front end");
    end
    if (dep_hit && !taken) begin
      p_dep_stalls_r1: assert (stall) else $error("dependence did not stall");
    end
  end
endmodule

// File: tb/test_ctrl_hazard_unit.sv
module test_ctrl_hazard_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] cls_d, cls_e;
  logic [4:0] src1_d, src2_d, dst_e, dst_m, dst_w;
  logic src1_rd_d, src2_rd_d, zero_e, wen_e, wen_m, wen_w;
  logic [1:0] next_pc_sel;
  logic dec_ir_nop, exe_ir_nop, stall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ctrl_hazard_unit i_ctrl_hazard_unit (
    .cls_d(cls_d), .src1_d(src1_d), .src1_rd_d(src1_rd_d),
    .src2_d(src2_d), .src2_rd_d(src2_rd_d), .cls_e(cls_e), .zero_e(zero_e),
    .dst_e(dst_e), .wen_e(wen_e), .dst_m(dst_m), .wen_m(wen_m),
    .dst_w(dst_w), .wen_w(wen_w), .next_pc_sel(next_pc_sel),
    .dec_ir_nop(dec_ir_nop), .exe_ir_nop(exe_ir_nop), .stall(stall)
  );

  function automatic bit f_taken();
    return (cls_e == 4'd3 && zero_e) || (cls_e == 4'd4 && !zero_e);
  endfunction

  function automatic bit f_src_dep(input logic [4:0] s, input bit rd);
    if (!rd || s == 5'd0) return 1'b0;
    return (wen_e && s == dst_e) || (wen_m && s == dst_m) || (wen_w && s == dst_w);
  endfunction

  function automatic bit f_stall();
    return (f_src_dep(src1_d, src1_rd_d) || f_src_dep(src2_d, src2_rd_d)) && !f_taken();
  endfunction

  function automatic logic [1:0] f_pc();
    if (f_taken()) return 2'd3;
    if (f_stall()) return 2'd0;
    if (cls_d == 4'd5 || cls_d == 4'd6) return 2'd1;
    if (cls_d == 4'd7 || cls_d == 4'd8) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit f_dnop();
    return f_taken() || (cls_d >= 4'd5 && cls_d <= 4'd8 && !f_stall());
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " stall"}, {1'b0, stall}, {1'b0, f_stall()});
    chk({tag, " pc_sel"}, next_pc_sel, f_pc());
    chk({tag, " dec_nop"}, {1'b0, dec_ir_nop}, {1'b0, f_dnop()});
    chk({tag, " exe_nop"}, {1'b0, exe_ir_nop}, {1'b0, f_taken() || f_stall()});
  endtask

  task automatic quiet();
    cls_d = 4'd0; cls_e = 4'd0; zero_e = 0;
    src1_d = 0; src2_d = 0; src1_rd_d = 0; src2_rd_d = 0;
    dst_e = 0; dst_m = 0; dst_w = 0; wen_e = 0; wen_m = 0; wen_w = 0;
  endtask

  task automatic apply_and_check(input string tag);
    #2;
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    quiet();
    @(negedge clk);
    // reset-like quiet state: no hazard, sequential fetch
    #2;
    chk("R6 idle pc", next_pc_sel, 2'd0);
    chk("R1 idle stall", {1'b0, stall}, 2'd0);
    @(negedge clk);

    // R1: src1 matches memory stage
    quiet(); src1_d = 5'd7; src1_rd_d = 1; dst_m = 5'd7; wen_m = 1;
    apply_and_check("R1 mem match");
    // R2: src2 matches writeback; and same with read disabled
    quiet(); src2_d = 5'd9; src2_rd_d = 1; dst_w = 5'd9; wen_w = 1;
    apply_and_check("R2 wb match");
    src2_rd_d = 0;
    apply_and_check("R2 read off");
    // R3: register zero
    quiet(); src1_d = 0; src1_rd_d = 1; src2_d = 0; src2_rd_d = 1; wen_e = 1; dst_e = 0;
    apply_and_check("R3 zero reg");
    // R4: taken branch cancels stall and beats jump
    quiet(); cls_e = 4'd3; zero_e = 1; cls_d = 4'd7; src1_d = 5'd4; src1_rd_d = 1;
    dst_e = 5'd4; wen_e = 1;
    apply_and_check("R4 beqz taken");
    cls_e = 4'd4; zero_e = 0;
    apply_and_check("R4 bnez taken");
    // R10: not-taken branches
    zero_e = 1;
    apply_and_check("R10 bnez not taken");
    cls_e = 4'd3; zero_e = 0; wen_e = 0;
    apply_and_check("R10 beqz not taken");
    // R6 / R7: each jump class without stall
    for (int c = 5; c <= 8; c++) begin
      quiet(); cls_d = 4'(c);
      apply_and_check("R7 jump");
    end
    // R9: jump waiting on interlock
    quiet(); cls_d = 4'd8; src1_d = 5'd2; src1_rd_d = 1; dst_e = 5'd2; wen_e = 1;
    apply_and_check("R9 stalled jump");
    // R5: unused class codes
    quiet(); cls_d = 4'd12; cls_e = 4'd14;
    apply_and_check("R5 spare code");

    // random stimulus, narrow register range for frequent matches (R1 R2 R3 R8)
    for (int i = 0; i < 4000; i++) begin
      cls_d = 4'($urandom_range(0, 11));
      cls_e = 4'($urandom_range(0, 11));
      zero_e = 1'($urandom);
      src1_d = 5'($urandom_range(0, 3)); src2_d = 5'($urandom_range(0, 3));
      src1_rd_d = 1'($urandom); src2_rd_d = 1'($urandom);
      dst_e = 5'($urandom_range(0, 3)); dst_m = 5'($urandom_range(0, 3));
      dst_w = 5'($urandom_range(0, 3));
      wen_e = 1'($urandom); wen_m = 1'($urandom); wen_w = 1'($urandom);
      apply_and_check("R8 random");
    end
    finish_run();
  end
endmodule